// File: doc/BRIEF.md
# Chainable Synchronous Up-Counter with Preset and Short Modulus

This block is a binary up-counter built from 4-bit slices that share one clock. Each slice has a synchronous clear, a synchronous parallel preset, and two count-enable inputs. Only one of the two enables, the carry-enable, is passed on through the slice's carry output. Chaining the carry output of each slice into the carry-enable of the next, more significant slice gives a wider counter that steps as one register, with no glue logic between slices.

The top level joins a chosen number of slices. A modulus parameter can make the count cycle shorter. A combinational compare looks for the value modulus-1 and forces the shared clear, so on the next edge the counter goes back to zero. The block is meant for timers and dividers that need a presettable count and a carry flag that a further stage can use as its enable.

Top module: `ctr_cascade`

## Requirements
- R1: All state bits of all slices update on the same rising clock edge. A counting edge adds exactly 1 to the whole chain value, taken modulo 2^(4·N_SLICES).
- R2: When clr_n is 0 at a rising edge, the count becomes 0 on that edge, whatever the values of load_n, en_p and en_t.
- R3: When load_n is 0 and clr_n is 1 at a rising edge, the count takes the value of load_data on that edge, whatever the values of en_p and en_t.
- R4: When clr_n and load_n are both 1, the count increments if en_p and en_t are both 1 at the edge, and holds its value otherwise.
- R5: carry_out is 1 exactly when en_t is 1 and every count bit is 1. en_p has no effect on carry_out.
- R6: When counting is enabled at the all-ones value, the count wraps to 0, and carry_out falls together with the wrap.
- R7: When MODULUS is less than 2^(4·N_SLICES), a count equal to MODULUS-1 becomes 0 on the next edge. This holds regardless of load_n, en_p and en_t, so the counter cycles through 0 to MODULUS-1.
- R8: A slice above the lowest one increments only when every lower slice is at 1111 and en_t is 1, because each slice's carry output drives the carry-enable of the slice above it.
- R9: While rst_n is 0, the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all slices |
| rst_n | input | 1 | Asynchronous active-low reset to zero |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous preset, active low |
| en_p | input | 1 | Count enable that has no effect on the carry |
| en_t | input | 1 | Count enable that also gates carry_out |
| load_data | input | 4·N_SLICES | Preset value |
| count | output | 4·N_SLICES | Current count |
| carry_out | output | 1 | High when en_t is 1 and the count is all ones |

## Verification
Clear, preset and increment can all be requested on the same edge. In a shortened configuration, the modulus decode can also fire while a preset or increment is requested. The bench drives random mixes of clr_n, load_n, en_p and en_t in every cycle on a full-width 12-bit chain and on an 8-bit chain with modulus 200. A bench model applies the order clear, then decode, then preset, then count, and the count is compared with it after every edge. Directed cases preset the all-ones value with only one of the two enables high and check the carry. They also step the chain across slice boundaries.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  localparam int SLICE_W = 4;

  typedef logic [SLICE_W-1:0] nib_t;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } slice_op_e;

  // Fixed priority: clear, then preset, then count.
  function automatic slice_op_e pick_op(input logic clr_n, input logic load_n,
                                        input logic en_p, input logic en_t);
    slice_op_e op;
    if (!clr_n)              op = OP_CLEAR;
    else if (!load_n)        op = OP_LOAD;
    else if (en_p && en_t)   op = OP_COUNT;
    else                     op = OP_HOLD;
    return op;
  endfunction

  function automatic nib_t apply_op(input slice_op_e op, input nib_t q, input nib_t d);
    nib_t r;
    case (op)
      OP_CLEAR: r = '0;
      OP_LOAD:  r = d;
      OP_COUNT: r = q + nib_t'(1);
      default:  r = q;
    endcase
    return r;
  endfunction

  function automatic logic at_terminal(input nib_t q);
    return &q;
  endfunction
endpackage

// File: rtl/ctr_slice.sv
module ctr_slice
  import ctr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  input  logic load_n,
  input  logic en_p,
  input  logic en_t,
  input  nib_t d,
  output nib_t q,
  output logic rco
);
  slice_op_e op;
  nib_t      q_nxt;

  assign op    = pick_op(clr_n, load_n, en_p, en_t);
  assign q_nxt = apply_op(op, q, d);
  assign rco   = en_t & at_terminal(q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> q == '0);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |=> q == $past(d));

  assert_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && en_p && en_t) |=> q == nib_t'($past(q) + nib_t'(1)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !(en_p && en_t)) |=> $stable(q));
endmodule

// File: rtl/ctr_mod_decode.sv
module ctr_mod_decode #(
  parameter int W       = 12,
  parameter int MODULUS = 4096
) (
  input  logic [W-1:0] count,
  input  logic         clr_n_in,
  output logic         clr_n_out,
  output logic         hit
);
  localparam longint FULL  = longint'(1) << W;
  localparam bit     SHORT = longint'(MODULUS) < FULL;
  localparam logic [W-1:0] LAST = W'(MODULUS - 1);

  generate
    if (SHORT) begin : g_short
      assign hit = (count == LAST);
    end else begin : g_full
      assign hit = 1'b0;
    end
  endgenerate

  assign clr_n_out = clr_n_in & ~hit;
endmodule

// File: rtl/ctr_cascade.sv
module ctr_cascade
  import ctr_pkg::*;
#(
  parameter int N_SLICES = 3,
  parameter int MODULUS  = 2 ** (4 * N_SLICES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_n,
  input  logic                          load_n,
  input  logic                          en_p,
  input  logic                          en_t,
  input  logic [N_SLICES*SLICE_W-1:0]   load_data,
  output logic [N_SLICES*SLICE_W-1:0]   count,
  output logic                          carry_out
);
  localparam int W = N_SLICES * SLICE_W;
  localparam longint FULL = longint'(1) << W;
  localparam bit SHORT = longint'(MODULUS) < FULL;

  logic              clr_n_eff;
  logic              mod_hit;
  logic [N_SLICES:0] ent_chain;

  ctr_mod_decode #(.W(W), .MODULUS(MODULUS)) u_dec (
    .count     (count),
    .clr_n_in  (clr_n),
    .clr_n_out (clr_n_eff),
    .hit       (mod_hit)
  );

  assign ent_chain[0] = en_t;

  generate
    for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
      ctr_slice u_slice (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_n  (clr_n_eff),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (ent_chain[i]),
        .d      (load_data[i*SLICE_W +: SLICE_W]),
        .q      (count[i*SLICE_W +: SLICE_W]),
        .rco    (ent_chain[i+1])
      );

      if (i > 0) begin : g_upper
        assert_cascade_R8: assert property (@(posedge clk) disable iff (!rst_n)
          (clr_n_eff && load_n && en_p && en_t && !(&count[i*SLICE_W-1:0]))
          |=> $stable(count[i*SLICE_W +: SLICE_W]));
      end
    end
  endgenerate

  assign carry_out = ent_chain[N_SLICES];

  assert_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n_eff && load_n && en_p && en_t) |=> count == W'($past(count) + W'(1)));

  assert_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> (en_t && (&count)));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n_eff && load_n && en_p && en_t && (&count)) |=> (count == '0 && !carry_out));

  generate
    if (SHORT) begin : g_mod_chk
      assert_modulus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mod_hit |=> count == '0);
    end
  endgenerate
endmodule

// File: tb/ctr_cascade_tb.sv
`timescale 1ns/1ps
module ctr_cascade_tb;
  localparam int MOD_B = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_n = 1'b1, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [11:0] load_data = '0;
  logic [11:0] count;
  logic        carry_out;
  logic [7:0]  count_b;
  logic        carry_b;

  int tests = 0;
  int failed = 0;
  logic [11:0] exp_a = '0;
  logic [7:0]  exp_b = '0;

  always #10 clk = ~clk;

  ctr_cascade #(.N_SLICES(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .en_p(en_p), .en_t(en_t), .load_data(load_data),
    .count(count), .carry_out(carry_out)
  );

  ctr_cascade #(.N_SLICES(2), .MODULUS(MOD_B)) u_dut_mod (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .en_p(en_p), .en_t(en_t), .load_data(load_data[7:0]),
    .count(count_b), .carry_out(carry_b)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // One clock cycle: apply inputs, check carry, then check count after the edge.
  task automatic step(input logic c, input logic l, input logic p, input logic t,
                      input logic [11:0] d, input string tag);
    string ta;
    logic exp_ca, exp_cb;
    clr_n = c; load_n = l; en_p = p; en_t = t; load_data = d;
    #2;
    exp_ca = t && (exp_a == 12'hFFF);
    exp_cb = t && (exp_b == 8'hFF);
    chk(carry_out == exp_ca, "R5 carry chain A", 32'(carry_out), 32'(exp_ca));
    chk(carry_b == exp_cb, "R5 carry chain B", 32'(carry_b), 32'(exp_cb));
    if (!c)              begin exp_a = '0; ta = "R2"; end
    else if (!l)         begin exp_a = d;  ta = "R3"; end
    else if (p && t)     begin exp_a = exp_a + 12'd1; ta = "R4 count"; end
    else                 ta = "R4 hold";
    if (!c || exp_b == 8'(MOD_B - 1)) exp_b = '0;
    else if (!l)                      exp_b = d[7:0];
    else if (p && t)                  exp_b = exp_b + 8'd1;
    if (tag != "") ta = tag;
    @(posedge clk);
    @(negedge clk);
    chk(count == exp_a, {ta, " count A"}, 32'(count), 32'(exp_a));
    chk(count_b == exp_b, "R7 count B", 32'(count_b), 32'(exp_b));
  endtask

  initial begin
    #(200000 * 20);
    failed++;
    tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    // R9: reset holds zero even with counting requested
    en_p = 1'b1; en_t = 1'b1;
    repeat (3) @(negedge clk);
    chk(count == '0, "R9 reset A", 32'(count), 32'h0);
    chk(count_b == '0, "R9 reset B", 32'(count_b), 32'h0);
    rst_n = 1'b1;
    en_p = 1'b0; en_t = 1'b0;

    // R1/R6/R8: full run through every value and across slice boundaries
    for (int i = 0; i < 4100; i++) step(1, 1, 1, 1, 12'h000, "R1");

    // R5: preset all ones, only en_t high -> carry up, no count
    step(1, 0, 0, 0, 12'hFFF, "R3");
    step(1, 1, 0, 1, 12'h000, "R5");
    step(1, 1, 1, 0, 12'h000, "R5");
    step(1, 1, 1, 1, 12'h000, "R6");
    step(1, 1, 1, 1, 12'h000, "R6");

    // R8: step across lower slice boundaries
    step(1, 0, 1, 1, 12'h0FF, "R3");
    step(1, 1, 1, 1, 12'h000, "R8");
    step(1, 0, 1, 1, 12'h3EF, "R3");
    step(1, 1, 1, 1, 12'h000, "R8");
    step(1, 1, 1, 0, 12'h000, "R8");

    // R2: clear wins over everything
    step(0, 0, 1, 1, 12'hABC, "R2");

    // R7: mod instance at last value with preset requested
    step(1, 0, 0, 0, 12'h0C7, "R3");
    step(1, 0, 1, 1, 12'h055, "R7");

    // mixed sweep
    for (int i = 0; i < 3000; i++) begin
      logic c, l, p, t;
      logic [11:0] d;
      c = (($urandom % 8) != 0);
      l = (($urandom % 4) != 0);
      p = 1'($urandom);
      t = 1'($urandom);
      d = ((($urandom % 4) == 0) ? 12'hFFF : 12'($urandom));
      step(c, l, p, t, d, "");
    end

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule